// File: doc/BRIEF.md
# Trap-Based TLB Miss Filter Controller

This block stands behind a hardware-managed primary TLB. It models a configurable set-associative secondary translation buffer. The only state it needs from each page entry is two status bits: a software-valid bit, which says the page is resident in memory, and a present bit, which says the entry sits in the emulated buffer. A primary-TLB miss arrives as one event carrying the entry's status bits, its set index and its tag. The controller sorts the event into one of three outcomes: a true page fault to forward, an entry to load into the emulated buffer, or an illegal status code. It then issues fill, evict and trap commands and counts the misses that cause a load.

Each set holds WAYS entries, a rotating pointer and one trapped victim way. The victim stands in for a not-most-recently-used entry without keeping any reference history. A reference to the victim moves the trap to the pointed way. A load into a full set evicts the victim, and the trap then moves on. Software uses an insert event to place a newly validated entry into the buffer; insert events are not counted as misses.

Top module: `trap_tlb_filter`

## Requirements
- R1: After reset, every command output is low and the miss counter is 0. In every set all ways are empty, the victim is way 0 and the pointer is way 1.
- R2: A miss event with status code 00 (software-valid=0, present=0) raises fault_o for one cycle and issues no fill or evict.
- R3: Any event, miss or insert, carrying the forbidden code 01 (software-valid=0, present=1) raises error_o for one cycle and issues no command. Buffer state is left unchanged.
- R4: A miss event with code 11 is ignored: no command, no counter change, no state change.
- R5: On a miss with code 10, if the pointed way is empty the tag is filled there and the pointer advances by one modulo WAYS, skipping the victim way. Otherwise, if the victim way is empty, the tag is filled there and the pointer does not move.
- R6: On a miss with code 10 into a full set whose victim does not hold the tag, the victim's entry is evicted and the new tag is filled into that way. The trap moves to the pointed way, and the pointer then advances past it.
- R7: An evicted entry is reported with its present bit cleared (evict_present_o=0) and its software-valid bit kept at 1.
- R8: A miss whose tag matches the entry in the victim way moves the trap to the pointed way and advances the pointer. It issues no fill or evict and leaves the counter unchanged.
- R9: miss_count_o rises by one for each miss event that fills (R5 or R6) and holds otherwise.
- R10: An insert event (ev_insert_i=1) fills or replaces as in R5 and R6. It never checks for a victim match and never changes the counter.
- R11: All results appear on the outputs one cycle after the event. cmd_set_o carries the event's set, and each set keeps its own pointer, victim and entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_valid_i | input | 1 | Event strobe, one event per cycle |
| ev_insert_i | input | 1 | 1: software insert, 0: primary-TLB miss |
| ev_sw_valid_i | input | 1 | Software-valid (resident) status bit |
| ev_present_i | input | 1 | Present (in emulated buffer) status bit |
| ev_set_i | input | SET_W | Set index |
| ev_tag_i | input | TAG_W | Entry tag |
| fill_valid_o | output | 1 | Fill command |
| fill_way_o | output | WAY_W | Way being filled |
| fill_tag_o | output | TAG_W | Tag being filled |
| evict_valid_o | output | 1 | Evict command |
| evict_tag_o | output | TAG_W | Tag of evicted entry |
| evict_sw_valid_o | output | 1 | Software-valid bit of evicted entry |
| evict_present_o | output | 1 | Present bit of evicted entry |
| trap_valid_o | output | 1 | Trap moved to a new victim |
| trap_way_o | output | WAY_W | New victim way |
| cmd_set_o | output | SET_W | Set addressed by the commands |
| fault_o | output | 1 | True page fault forwarded |
| error_o | output | 1 | Forbidden status code seen |
| miss_count_o | output | CNT_W | Count of filling misses |

## Verification
The bench goes after four things: the first fill into an empty set, the moment a set becomes full, a reference to the trapped victim, and insert events aimed at a full set. A controller that forgot to skip the victim while advancing would evict the entry it had just trapped, and the evicted tag would then be wrong. One that checked inserts for a victim match, or counted them, would show a stray trap move or a counter step. Forbidden and ignored codes are also driven on sets that hold live entries. Leaking state there would surface in later fills as a wrong way. A long randomized stream over a small tag pool keeps hitting the victim and interleaves sets, which exposes any sharing of state between sets.

// File: rtl/ttf_pkg.sv
package ttf_pkg;
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_FAULT,
    ACT_ERROR,
    ACT_SWAP,
    ACT_FILL,
    ACT_REPLACE
  } act_e;
endpackage

// File: rtl/ttf_store.sv
module ttf_store #(
  parameter int SETS  = 8,
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [SET_W-1:0]             set_i,
  output logic [WAYS-1:0]              valid_o,
  output logic [WAYS-1:0][TAG_W-1:0]   tag_o,
  output logic [WAY_W-1:0]             victim_o,
  output logic [WAY_W-1:0]             ptr_o,
  input  logic                         wr_en_i,
  input  logic [WAY_W-1:0]             wr_way_i,
  input  logic [TAG_W-1:0]             wr_tag_i,
  input  logic                         meta_en_i,
  input  logic [WAY_W-1:0]             meta_victim_i,
  input  logic [WAY_W-1:0]             meta_ptr_i
);
  logic [WAYS-1:0]            valid_a  [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_a    [SETS];
  logic [WAY_W-1:0]           victim_a [SETS];
  logic [WAY_W-1:0]           ptr_a    [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic                       sel;
    logic [WAYS-1:0]            valid_q;
    logic [WAYS-1:0][TAG_W-1:0] tag_q;
    logic [WAY_W-1:0]           victim_q;
    logic [WAY_W-1:0]           ptr_q;

    assign sel = (set_i == SET_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q  <= '0;
        tag_q    <= '0;
        victim_q <= '0;
        ptr_q    <= WAY_W'(1);
      end else if (sel) begin
        if (wr_en_i) begin
          valid_q[wr_way_i] <= 1'b1;
          tag_q[wr_way_i]   <= wr_tag_i;
        end
        if (meta_en_i) begin
          victim_q <= meta_victim_i;
          ptr_q    <= meta_ptr_i;
        end
      end
    end

    assign valid_a[s]  = valid_q;
    assign tag_a[s]    = tag_q;
    assign victim_a[s] = victim_q;
    assign ptr_a[s]    = ptr_q;
  end

  assign valid_o  = valid_a[set_i];
  assign tag_o    = tag_a[set_i];
  assign victim_o = victim_a[set_i];
  assign ptr_o    = ptr_a[set_i];
endmodule

// File: rtl/ttf_policy.sv
module ttf_policy #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                       ev_valid_i,
  input  logic                       ev_insert_i,
  input  logic                       ev_sw_valid_i,
  input  logic                       ev_present_i,
  input  logic [TAG_W-1:0]           ev_tag_i,
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [WAY_W-1:0]           victim_i,
  input  logic [WAY_W-1:0]           ptr_i,
  output ttf_pkg::act_e              act_o,
  output logic [WAY_W-1:0]           way_o,
  output logic [WAY_W-1:0]           new_victim_o,
  output logic [WAY_W-1:0]           new_ptr_o,
  output logic [TAG_W-1:0]           evict_tag_o
);
  import ttf_pkg::*;

  // next way modulo WAYS, stepping over skip
  function automatic logic [WAY_W-1:0] step(input logic [WAY_W-1:0] p,
                                            input logic [WAY_W-1:0] skip);
    logic [WAY_W-1:0] n;
    n = (p == WAY_W'(WAYS-1)) ? '0 : p + 1'b1;
    if (n == skip) n = (n == WAY_W'(WAYS-1)) ? '0 : n + 1'b1;
    return n;
  endfunction

  logic vic_hit;
  logic forbidden;

  assign vic_hit   = valid_i[victim_i] && (tag_i[victim_i] == ev_tag_i);
  assign forbidden = !ev_sw_valid_i && ev_present_i;

  always_comb begin
    act_o        = ACT_NONE;
    way_o        = ptr_i;
    new_victim_o = victim_i;
    new_ptr_o    = ptr_i;
    evict_tag_o  = tag_i[victim_i];
    if (ev_valid_i) begin
      if (forbidden) begin
        act_o = ACT_ERROR;
      end else if (!ev_insert_i && !ev_sw_valid_i) begin
        act_o = ACT_FAULT;
      end else if (!ev_insert_i && ev_present_i) begin
        act_o = ACT_NONE;
      end else if (!ev_insert_i && vic_hit) begin
        act_o        = ACT_SWAP;
        new_victim_o = ptr_i;
        new_ptr_o    = step(ptr_i, ptr_i);
      end else if (!valid_i[ptr_i]) begin
        act_o     = ACT_FILL;
        new_ptr_o = step(ptr_i, victim_i);
      end else if (!valid_i[victim_i]) begin
        act_o = ACT_FILL;
        way_o = victim_i;
      end else begin
        act_o        = ACT_REPLACE;
        way_o        = victim_i;
        new_victim_o = ptr_i;
        new_ptr_o    = step(ptr_i, ptr_i);
      end
    end
  end
endmodule

// File: rtl/trap_tlb_filter.sv
module trap_tlb_filter #(
  parameter int SETS  = 8,
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  parameter int CNT_W = 16,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ev_valid_i,
  input  logic             ev_insert_i,
  input  logic             ev_sw_valid_i,
  input  logic             ev_present_i,
  input  logic [SET_W-1:0] ev_set_i,
  input  logic [TAG_W-1:0] ev_tag_i,
  output logic             fill_valid_o,
  output logic [WAY_W-1:0] fill_way_o,
  output logic [TAG_W-1:0] fill_tag_o,
  output logic             evict_valid_o,
  output logic [TAG_W-1:0] evict_tag_o,
  output logic             evict_sw_valid_o,
  output logic             evict_present_o,
  output logic             trap_valid_o,
  output logic [WAY_W-1:0] trap_way_o,
  output logic [SET_W-1:0] cmd_set_o,
  output logic             fault_o,
  output logic             error_o,
  output logic [CNT_W-1:0] miss_count_o
);
  import ttf_pkg::*;

  logic [WAYS-1:0]            rd_valid;
  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [WAY_W-1:0]           rd_victim, rd_ptr;
  act_e                       act;
  logic [WAY_W-1:0]           tgt_way, new_victim, new_ptr;
  logic [TAG_W-1:0]           vic_tag;
  logic                       do_fill, do_meta, do_count;

  ttf_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .set_i         (ev_set_i),
    .valid_o       (rd_valid),
    .tag_o         (rd_tag),
    .victim_o      (rd_victim),
    .ptr_o         (rd_ptr),
    .wr_en_i       (do_fill),
    .wr_way_i      (tgt_way),
    .wr_tag_i      (ev_tag_i),
    .meta_en_i     (do_meta),
    .meta_victim_i (new_victim),
    .meta_ptr_i    (new_ptr)
  );

  ttf_policy #(.WAYS(WAYS), .TAG_W(TAG_W)) u_policy (
    .ev_valid_i    (ev_valid_i),
    .ev_insert_i   (ev_insert_i),
    .ev_sw_valid_i (ev_sw_valid_i),
    .ev_present_i  (ev_present_i),
    .ev_tag_i      (ev_tag_i),
    .valid_i       (rd_valid),
    .tag_i         (rd_tag),
    .victim_i      (rd_victim),
    .ptr_i         (rd_ptr),
    .act_o         (act),
    .way_o         (tgt_way),
    .new_victim_o  (new_victim),
    .new_ptr_o     (new_ptr),
    .evict_tag_o   (vic_tag)
  );

  assign do_fill  = (act == ACT_FILL) || (act == ACT_REPLACE);
  assign do_meta  = do_fill || (act == ACT_SWAP);
  assign do_count = do_fill && !ev_insert_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_valid_o  <= 1'b0;
      fill_way_o    <= '0;
      fill_tag_o    <= '0;
      evict_valid_o <= 1'b0;
      evict_tag_o   <= '0;
      trap_valid_o  <= 1'b0;
      trap_way_o    <= '0;
      cmd_set_o     <= '0;
      fault_o       <= 1'b0;
      error_o       <= 1'b0;
      miss_count_o  <= '0;
    end else begin
      fill_valid_o  <= do_fill;
      fill_way_o    <= tgt_way;
      fill_tag_o    <= ev_tag_i;
      evict_valid_o <= (act == ACT_REPLACE);
      evict_tag_o   <= vic_tag;
      trap_valid_o  <= (act == ACT_SWAP) || (act == ACT_REPLACE);
      trap_way_o    <= new_victim;
      fault_o       <= (act == ACT_FAULT);
      error_o       <= (act == ACT_ERROR);
      if (ev_valid_i) cmd_set_o <= ev_set_i;
      if (do_count) miss_count_o <= miss_count_o + 1'b1;
    end
  end

  // evicted entry leaves resident but out of the emulated buffer
  assign evict_sw_valid_o = evict_valid_o;
  assign evict_present_o  = 1'b0;
endmodule

// File: rtl/ttf_chk.sv
module ttf_chk #(
  parameter int SETS  = 8,
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  parameter int CNT_W = 16,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ev_valid_i,
  input logic             ev_insert_i,
  input logic             ev_sw_valid_i,
  input logic             ev_present_i,
  input logic [SET_W-1:0] ev_set_i,
  input logic [TAG_W-1:0] ev_tag_i,
  input logic             fill_valid_o,
  input logic [WAY_W-1:0] fill_way_o,
  input logic [TAG_W-1:0] fill_tag_o,
  input logic             evict_valid_o,
  input logic [TAG_W-1:0] evict_tag_o,
  input logic             evict_sw_valid_o,
  input logic             evict_present_o,
  input logic             trap_valid_o,
  input logic [WAY_W-1:0] trap_way_o,
  input logic [SET_W-1:0] cmd_set_o,
  input logic             fault_o,
  input logic             error_o,
  input logic [CNT_W-1:0] miss_count_o
);
  // R2
  fault_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_i && !ev_insert_i && !ev_sw_valid_i && !ev_present_i
    |=> fault_o && !fill_valid_o && !evict_valid_o);

  // R3
  forbid_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_i && !ev_sw_valid_i && ev_present_i
    |=> error_o && !fill_valid_o && !trap_valid_o && !fault_o);

  // R4
  ignore_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_i && !ev_insert_i && ev_sw_valid_i && ev_present_i
    |=> !fill_valid_o && !trap_valid_o && !fault_o && !error_o && $stable(miss_count_o));

  // R6
  evict_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_o |-> fill_valid_o && trap_valid_o && (trap_way_o != fill_way_o));

  // R7
  evict_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_o |-> evict_sw_valid_o && !evict_present_o);

  // R9
  count_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_valid_i |=> $stable(miss_count_o));

  // R10
  insert_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_i && ev_insert_i |=> $stable(miss_count_o));

  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_valid_i |=> !fill_valid_o && !trap_valid_o && !fault_o && !error_o);
endmodule

bind trap_tlb_filter ttf_chk #(
  .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .CNT_W(CNT_W)
) u_ttf_chk (.*);

// File: tb/trap_tlb_filter_bench.sv
module trap_tlb_filter_bench;
  localparam int SETS  = 8;
  localparam int WAYS  = 4;
  localparam int TAG_W = 20;
  localparam int CNT_W = 16;
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             ev_valid_i = 1'b0, ev_insert_i = 1'b0;
  logic             ev_sw_valid_i = 1'b0, ev_present_i = 1'b0;
  logic [SET_W-1:0] ev_set_i = '0;
  logic [TAG_W-1:0] ev_tag_i = '0;
  logic             fill_valid_o, evict_valid_o, evict_sw_valid_o, evict_present_o;
  logic             trap_valid_o, fault_o, error_o;
  logic [WAY_W-1:0] fill_way_o, trap_way_o;
  logic [TAG_W-1:0] fill_tag_o, evict_tag_o;
  logic [SET_W-1:0] cmd_set_o;
  logic [CNT_W-1:0] miss_count_o;

  always #2 clk_i = ~clk_i;

  trap_tlb_filter #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_trap_tlb_filter (
    .clk_i, .rst_ni, .ev_valid_i, .ev_insert_i, .ev_sw_valid_i, .ev_present_i,
    .ev_set_i, .ev_tag_i, .fill_valid_o, .fill_way_o, .fill_tag_o, .evict_valid_o,
    .evict_tag_o, .evict_sw_valid_o, .evict_present_o, .trap_valid_o, .trap_way_o,
    .cmd_set_o, .fault_o, .error_o, .miss_count_o
  );

  typedef struct {
    bit fv; int fway; int ftag;
    bit ev; int etag;
    bit tv; int tway;
    int set; bit flt; bit err; int cnt;
  } exp_t;

  exp_t q[$];
  int   total = 0, fails = 0;
  bit   done = 0;

  // reference state built from the requirements
  bit mval [SETS][WAYS];
  int mtag [SETS][WAYS];
  int mvic [SETS];
  int mptr [SETS];
  int mcount = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int nxt(input int p, input int skip);
    int n = (p + 1) % WAYS;
    if (n == skip) n = (n + 1) % WAYS;
    return n;
  endfunction

  task automatic send(input bit vld, input bit ins, input bit sw, input bit pr,
                      input int set, input int tag);
    exp_t e;
    int v, p;
    bit filled;
    @(negedge clk_i);
    ev_valid_i    <= vld;
    ev_insert_i   <= ins;
    ev_sw_valid_i <= sw;
    ev_present_i  <= pr;
    ev_set_i      <= SET_W'(set);
    ev_tag_i      <= TAG_W'(tag);
    e = '{default: 0};
    filled = 0;
    if (vld) begin
      e.set = set;
      v = mvic[set];
      p = mptr[set];
      if (!sw && pr) e.err = 1;                       // R3
      else if (!ins && !sw) e.flt = 1;                // R2
      else if (!ins && pr) ;                          // R4 ignored
      else if (!ins && mval[set][v] && mtag[set][v] == tag) begin  // R8
        e.tv = 1; e.tway = p;
        mvic[set] = p; mptr[set] = nxt(p, p);
      end else if (!mval[set][p]) begin               // R5
        e.fv = 1; e.fway = p; e.ftag = tag;
        mval[set][p] = 1; mtag[set][p] = tag;
        mptr[set] = nxt(p, v); filled = 1;
      end else if (!mval[set][v]) begin
        e.fv = 1; e.fway = v; e.ftag = tag;
        mval[set][v] = 1; mtag[set][v] = tag; filled = 1;
      end else begin                                  // R6
        e.fv = 1; e.fway = v; e.ftag = tag;
        e.ev = 1; e.etag = mtag[set][v];
        e.tv = 1; e.tway = p;
        mtag[set][v] = tag;
        mvic[set] = p; mptr[set] = nxt(p, p); filled = 1;
      end
      if (filled && !ins) mcount = (mcount + 1) % (1 << CNT_W);  // R9, R10
    end
    e.cnt = mcount;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send(0, 0, 0, 0, 0, 0);
  endtask

  // monitor: one expected record per driven cycle
  initial begin
    exp_t e;
    forever begin
      @(posedge clk_i);
      #1;
      if (q.size() != 0) begin
        e = q.pop_front();
        chk("R5", "fill_valid", fill_valid_o, e.fv);
        if (e.fv) begin
          chk("R5", "fill_way", fill_way_o, e.fway);
          chk("R5", "fill_tag", fill_tag_o, e.ftag);
        end
        chk("R6", "evict_valid", evict_valid_o, e.ev);
        if (e.ev) begin
          chk("R6", "evict_tag", evict_tag_o, e.etag);
          chk("R7", "evict_sw_valid", evict_sw_valid_o, 1);
          chk("R7", "evict_present", evict_present_o, 0);
        end
        chk("R8", "trap_valid", trap_valid_o, e.tv);
        if (e.tv) chk("R8", "trap_way", trap_way_o, e.tway);
        chk("R2", "fault", fault_o, e.flt);
        chk("R3", "error", error_o, e.err);
        chk("R9", "miss_count", miss_count_o, e.cnt);
        if (e.fv || e.tv || e.flt || e.err) chk("R11", "cmd_set", cmd_set_o, e.set);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin
      mvic[s] = 0; mptr[s] = 1;
      for (int w = 0; w < WAYS; w++) begin mval[s][w] = 0; mtag[s][w] = 0; end
    end
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1", "fill_valid", fill_valid_o, 0);
    chk("R1", "trap_valid", trap_valid_o, 0);
    chk("R1", "fault", fault_o, 0);
    chk("R1", "error", error_o, 0);
    chk("R1", "miss_count", miss_count_o, 0);
    rst_ni = 1'b1;
    idle(2);
    // R2: true page fault
    send(1, 0, 0, 0, 3, 'h11);
    // R3: forbidden code on miss and insert
    send(1, 0, 0, 1, 3, 'h12);
    send(1, 1, 0, 1, 3, 'h13);
    // R4: code 11 ignored
    send(1, 0, 1, 1, 3, 'h14);
    // R5: fill empty set 2: ways 1,2,3 then victim way 0
    for (int i = 0; i < WAYS; i++) send(1, 0, 1, 0, 2, 'hA0 + i);
    // R6, R7: full set replacement
    send(1, 0, 1, 0, 2, 'hB0);
    // R8: victim is now way 1 holding 'hA0
    send(1, 0, 1, 0, 2, 'hA0);
    // R10: insert into full set, even with victim's tag
    send(1, 1, 1, 0, 2, 'hC0);
    send(1, 1, 1, 0, 2, 'hA2);
    // R4 on populated set, then refill
    send(1, 0, 1, 1, 2, 'hB0);
    send(1, 0, 1, 0, 2, 'hD0);
    // R11: interleaved sets
    for (int i = 0; i < 6; i++) begin
      send(1, 0, 1, 0, 5, 'h500 + i);
      send(1, 0, 1, 0, 6, 'h600 + i);
    end
    idle(2);
    // mixed stream over small tag pool
    for (int i = 0; i < 600; i++) begin
      int r = $urandom % 16;
      int s = $urandom % 4;
      int t = $urandom % 8;
      if (r < 9)       send(1, 0, 1, 0, s, t);
      else if (r < 11) send(1, 0, 0, 0, s, t);
      else if (r == 11) send(1, 0, 0, 1, s, t);
      else if (r == 12) send(1, 0, 1, 1, s, t);
      else if (r == 13) send(1, 1, 1, 0, s, t);
      else             send(0, 0, 0, 0, 0, 0);
    end
    idle(3);
    wait (q.size() == 0);
    @(negedge clk_i);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule